// File: doc/BRIEF.md
# Adaptive Coding Option Selector

This block sits next to a lossless sample coder. It takes blocks of mapped, non-negative 8-bit samples and works out the exact number of output bits that each candidate coding option would spend on the block. It then reports the cheapest option, so that a separate bitstream writer can encode the block with it. The candidates are:

- zero-block;
- second extension, which codes pairs of samples;
- plain comma code, a run of zeros ended by a one;
- six split-sample variants, which send the k low bits raw and comma-code the rest;
- uncompressed.

Samples arrive one per accepted cycle while `in_valid` is high. Blocks are delimited by counting accepted samples from reset, so `BLOCK_LEN` accepted samples form one block. `BLOCK_LEN` must be even and at least 2. All running costs are updated as each sample is accepted. The decision appears a fixed two cycles after the last sample of the block is presented. A new block may start in the cycle that directly follows the previous one, with no idle cycle in between.

Top module: `rice_opt_sel`

## Requirements
- R1: `dec_valid` is high for exactly one cycle. That cycle follows the clock edge after the edge that accepted the `BLOCK_LEN`-th sample of a block. Cycles with `in_valid` low neither count as samples nor move the decision.
- R2: `dec_bits` equals the smallest cost among the eligible options. `dec_id` and `dec_sub` name that option.
- R3: The comma-code option costs 5 + Σ(δ+1). It is reported as `dec_id` 000 with `dec_sub` 10.
- R4: Split option k, for k from 1 to 6, costs 3 + Σ(k + (δ>>k) + 1). It is reported as `dec_id` = k and `dec_sub` 00.
- R5: The second-extension option pairs samples at positions (0,1), (2,3) and so on as (a,b). It costs 5 + Σ(γ+1), where γ = (a+b)(a+b+1)/2 + b. It is reported as `dec_id` 000 with `dec_sub` 01.
- R6: The zero-block option is eligible only when every sample of the block is zero. It costs 6 bits and is reported as `dec_id` 000 with `dec_sub` 00.
- R7: The uncompressed option costs 3 + 8·`BLOCK_LEN`. It is reported as `dec_id` 111 with `dec_sub` 00, and it is chosen only when no other option is cheaper.
- R8: When costs are equal, the winner is the earliest option in this order: zero-block, second extension, comma code, split k=1 through k=6, uncompressed.
- R9: Each per-option sum saturates at 65535 and never wraps. Adding the identifier overhead also saturates at 65535. An overflowing second-extension sum therefore cannot beat a cheaper option.
- R10: After reset, `dec_valid`, `dec_id`, `dec_sub` and `dec_bits` are zero. A partially received block is discarded, and counting restarts at the first sample accepted after reset.
- R11: The first sample of the next block may be accepted in the same cycle that the previous decision is produced. Both results are then correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | 8 | Mapped sample value δ |
| dec_valid | output | 1 | Decision strobe, one cycle |
| dec_id | output | 3 | Identifier of the chosen option |
| dec_sub | output | 2 | Sub-selector when `dec_id` is 000, otherwise 00 |
| dec_bits | output | 16 | Coded length of the block with the chosen option |

## Verification
The decision for one block and the first sample of the next block can land in the same cycle. In that cycle the selector must read the finished sums of the old block while every accumulator and the zero flag restart on the new sample. The bench provokes this by streaming blocks back to back with no idle cycle. One pair is chosen so that a non-zero block is followed directly by an all-zero block. Each decision is then judged against an arithmetic model of that block alone. A sum or flag that leaks from the old block into the new one shows up as a wrong winner or a wrong bit count.

// File: rtl/rice_opt_pkg.sv
package rice_opt_pkg;

    localparam int SAMP_W  = 8;
    localparam int COST_W  = 16;
    localparam int ID_W    = 3;
    localparam int SUB_W   = 2;
    localparam int K_MAX   = 6;
    localparam int N_OPT   = K_MAX + 4;
    localparam int GAMMA_W = 2 * SAMP_W + 1;
    localparam int WIDE_W  = GAMMA_W + 1;

    // candidate slots, listed in tie-break order
    localparam int IX_ZERO = 0;
    localparam int IX_SE   = 1;
    localparam int IX_FS   = 2;
    localparam int IX_K1   = 3;
    localparam int IX_RAW  = N_OPT - 1;

    localparam logic [ID_W-1:0]  ID_LOW   = 3'd0;
    localparam logic [ID_W-1:0]  ID_RAW   = 3'd7;
    localparam logic [SUB_W-1:0] SUB_ZERO = 2'd0;

    typedef logic [COST_W-1:0]  cost_t;
    typedef logic [GAMMA_W-1:0] inc_t;
    typedef logic [WIDE_W-1:0]  wide_t;

    localparam cost_t COST_SAT = '1;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [SUB_W-1:0] sub;
        cost_t            bits;
    } pick_t;

    function automatic cost_t sat_add(cost_t acc, inc_t inc);
        wide_t sum;
        sum = wide_t'(acc) + wide_t'(inc);
        return (sum > wide_t'(COST_SAT)) ? COST_SAT : sum[COST_W-1:0];
    endfunction

    // pair index of the second extension
    function automatic inc_t gamma_f(logic [SAMP_W-1:0] a, logic [SAMP_W-1:0] b);
        logic [SAMP_W:0]  s;
        logic [WIDE_W:0]  prod;
        s    = {1'b0, a} + {1'b0, b};
        prod = (WIDE_W+1)'(s) * ((WIDE_W+1)'(s) + 1'b1);
        return prod[GAMMA_W:1] + inc_t'(b);
    endfunction

    function automatic inc_t split_inc(int k, logic [SAMP_W-1:0] d);
        inc_t hi;
        hi = inc_t'(d >> k);
        return hi + inc_t'(k + 1);
    endfunction

    function automatic logic [ID_W-1:0] opt_id(int i);
        if (i <= IX_FS)  return ID_LOW;
        if (i == IX_RAW) return ID_RAW;
        return ID_W'(i - IX_K1 + 1);
    endfunction

    function automatic logic [SUB_W-1:0] opt_sub(int i);
        return (i <= IX_FS) ? SUB_W'(i) : SUB_ZERO;
    endfunction

    function automatic inc_t opt_ovh(int i);
        return (i <= IX_FS) ? inc_t'(ID_W + SUB_W) : inc_t'(ID_W);
    endfunction

endpackage

// File: rtl/rice_cost_acc.sv
module rice_cost_acc
    import rice_opt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  first,
    input  inc_t  inc,
    output cost_t acc
);

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (en)
            acc <= sat_add(first ? '0 : acc, inc);
    end

    AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en && !first) |=> (acc >= $past(acc)));  // R9

endmodule

// File: rtl/rice_opt_pick.sv
module rice_opt_pick
    import rice_opt_pkg::*;
(
    input  logic [N_OPT-1:0][COST_W-1:0] sums,
    input  logic [N_OPT-1:0]             elig,
    output pick_t                        best
);

    cost_t cand;
    logic  found;

    always_comb begin
        best  = '{id: ID_RAW, sub: SUB_ZERO, bits: COST_SAT};
        found = 1'b0;
        cand  = '0;
        for (int i = 0; i < N_OPT; i++) begin
            cand = sat_add(sums[i], opt_ovh(i));
            // strict compare keeps the earlier slot on a tie
            if (elig[i] && (!found || cand < best.bits)) begin
                best.id   = opt_id(i);
                best.sub  = opt_sub(i);
                best.bits = cand;
                found     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rice_opt_sel.sv
module rice_opt_sel
    import rice_opt_pkg::*;
#(
    parameter int BLOCK_LEN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [SAMP_W-1:0] in_sample,
    output logic              dec_valid,
    output logic [ID_W-1:0]   dec_id,
    output logic [SUB_W-1:0]  dec_sub,
    output logic [COST_W-1:0] dec_bits
);

    localparam int CNT_W   = (BLOCK_LEN > 2) ? $clog2(BLOCK_LEN) : 1;
    localparam int RAW_SUM = SAMP_W * BLOCK_LEN;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK_LEN - 1);

    logic [CNT_W-1:0]  cnt;
    logic [SAMP_W-1:0] held;
    logic              all_zero;
    logic              done;
    pick_t             best;
    pick_t             dec_q;

    logic [N_OPT-1:0][COST_W-1:0] sums;
    logic [N_OPT-1:0]             elig;

    wire blk_first = (cnt == '0);
    wire blk_last  = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            held     <= '0;
            all_zero <= 1'b0;
        end else if (in_valid) begin
            cnt      <= blk_last ? '0 : cnt + 1'b1;
            all_zero <= (blk_first || all_zero) && (in_sample == '0);
            if (!cnt[0])
                held <= in_sample;
        end
    end

    rice_cost_acc u_acc_fs (
        .clk   (clk),
        .rst   (rst),
        .en    (in_valid),
        .first (blk_first),
        .inc   (inc_t'(in_sample) + 1'b1),
        .acc   (sums[IX_FS])
    );

    rice_cost_acc u_acc_se (
        .clk   (clk),
        .rst   (rst),
        .en    (in_valid && cnt[0]),
        .first (cnt == CNT_W'(1)),
        .inc   (gamma_f(held, in_sample) + 1'b1),
        .acc   (sums[IX_SE])
    );

    for (genvar k = 1; k <= K_MAX; k++) begin : g_split
        rice_cost_acc u_acc_k (
            .clk   (clk),
            .rst   (rst),
            .en    (in_valid),
            .first (blk_first),
            .inc   (split_inc(k, in_sample)),
            .acc   (sums[IX_K1+k-1])
        );
    end

    assign sums[IX_ZERO] = cost_t'(1);
    assign sums[IX_RAW]  = cost_t'(RAW_SUM);
    assign elig          = {1'b1, {K_MAX{1'b1}}, 1'b1, 1'b1, all_zero};

    rice_opt_pick u_pick (
        .sums (sums),
        .elig (elig),
        .best (best)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            dec_valid <= 1'b0;
            dec_q     <= '0;
        end else begin
            done      <= in_valid && blk_last;
            dec_valid <= done;
            if (done)
                dec_q <= best;
        end
    end

    assign dec_id   = dec_q.id;
    assign dec_sub  = dec_q.sub;
    assign dec_bits = dec_q.bits;

    AST_DEC_PULSE: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);  // R1
    AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && blk_last) |-> ##2 dec_valid);  // R1
    AST_RAW_CAP: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (dec_bits <= cost_t'(RAW_SUM + ID_W)));  // R7
    AST_SUB_ONLY_LOW: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_sub != SUB_ZERO) |-> (dec_id == ID_LOW));  // R2
    AST_ZERO_NEEDS_ZEROS: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_id == ID_LOW && dec_sub == SUB_ZERO) |-> $past(all_zero));  // R6

endmodule

// File: tb/rice_opt_sel_tb_top.sv
`timescale 1ns/1ps
module rice_opt_sel_tb_top;

    localparam int BL = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_sample = '0;
    logic       dec_valid;
    logic [2:0] dec_id;
    logic [1:0] dec_sub;
    logic [15:0] dec_bits;

    int n_chk  = 0;
    int n_fail = 0;

    // expectation pipeline: slot0 = set this step, slot1 = due now
    bit    p0_v, p1_v, nx_v;
    int    p0_id, p0_sub, p0_bits, p1_id, p1_sub, p1_bits, nx_id, nx_sub, nx_bits;
    string p0_tag, p1_tag, nx_tag;
    int unsigned lfsr = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    rice_opt_sel #(.BLOCK_LEN(BL)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .dec_valid (dec_valid),
        .dec_id    (dec_id),
        .dec_sub   (dec_sub),
        .dec_bits  (dec_bits)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > 65535) ? 65535 : v;
    endfunction

    task automatic model(input int b[BL], output int id, output int sub, output int bits, output bit tie);
        int  c[10];
        bit  el[10];
        int  sk[7];
        int  fs, se, best, g;
        bit  z;
        fs = 0; se = 0; z = 1'b1;
        for (int k = 0; k < 7; k++) sk[k] = 0;
        for (int i = 0; i < BL; i++) begin
            fs += b[i] + 1;
            if (b[i] != 0) z = 1'b0;
            for (int k = 1; k <= 6; k++) sk[k] += k + (b[i] >> k) + 1;
        end
        for (int p = 0; p < BL; p += 2) begin
            g = (b[p] + b[p+1]) * (b[p] + b[p+1] + 1) / 2 + b[p+1];
            se += g + 1;
        end
        for (int i = 0; i < 10; i++) el[i] = 1'b1;
        el[0] = z;
        c[0]  = 6;
        c[1]  = sat(sat(se) + 5);
        c[2]  = sat(sat(fs) + 5);
        for (int k = 1; k <= 6; k++) c[2+k] = sat(sat(sk[k]) + 3);
        c[9]  = 3 + 8 * BL;
        best = -1;
        for (int i = 0; i < 10; i++)
            if (el[i] && (best < 0 || c[i] < c[best])) best = i;
        tie = 1'b0;
        for (int i = 0; i < 10; i++)
            if (el[i] && i != best && c[i] == c[best]) tie = 1'b1;
        id   = (best < 3) ? 0 : (best == 9) ? 7 : best - 2;
        sub  = (best < 3) ? best : 0;
        bits = c[best];
    endtask

    task automatic step(input bit v, input int d, input bit mark);
        @(negedge clk);
        if (p1_v) begin
            chk(dec_valid == 1'b1, "R1", "decision strobe", int'(dec_valid), 1);
            chk(dec_id == p1_id[2:0] && dec_sub == p1_sub[1:0], {p1_tag, "/R2"}, "option id*4+sub",
                int'(dec_id) * 4 + int'(dec_sub), p1_id * 4 + p1_sub);
            chk(int'(dec_bits) == p1_bits, {p1_tag, "/R2"}, "bit count", int'(dec_bits), p1_bits);
        end else begin
            chk(dec_valid == 1'b0, "R1", "no strobe expected", int'(dec_valid), 0);
        end
        p1_v = p0_v; p1_id = p0_id; p1_sub = p0_sub; p1_bits = p0_bits; p1_tag = p0_tag;
        p0_v = mark; p0_id = nx_id; p0_sub = nx_sub; p0_bits = nx_bits; p0_tag = nx_tag;
        in_valid  = v;
        in_sample = 8'(d);
    endtask

    task automatic send_block(input int b[BL], input int gap, input string force_tag);
        int  id, sub, bits;
        bit  tie;
        model(b, id, sub, bits, tie);
        nx_id = id; nx_sub = sub; nx_bits = bits;
        if (force_tag != "")     nx_tag = force_tag;
        else if (tie)            nx_tag = "R8";
        else if (id == 7)        nx_tag = "R7";
        else if (id != 0)        nx_tag = "R4";
        else if (sub == 0)       nx_tag = "R6";
        else if (sub == 1)       nx_tag = "R5";
        else                     nx_tag = "R3";
        for (int i = 0; i < BL; i++) begin
            if (gap > 0 && (i % 3) == 1)
                for (int g = 0; g < gap; g++) step(1'b0, 0, 1'b0);
            step(1'b1, b[i], i == BL - 1);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) step(1'b0, 0, 1'b0);
    endtask

    function automatic int next_val();
        lfsr ^= lfsr << 13;
        lfsr ^= lfsr >> 17;
        lfsr ^= lfsr << 5;
        return (lfsr[9:8] == 2'b11) ? int'(lfsr[23:16]) : int'(lfsr[3:0]);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        int b[BL];
        p0_v = 0; p1_v = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(dec_valid == 1'b0, "R10", "reset valid", int'(dec_valid), 0);
        chk(dec_id == 3'd0 && dec_sub == 2'd0, "R10", "reset id/sub", int'(dec_id) * 4 + int'(dec_sub), 0);
        chk(dec_bits == 16'd0, "R10", "reset bits", int'(dec_bits), 0);
        rst = 1'b0;

        // constant blocks over every value (0 -> zero-block, 3 -> split tie)
        for (int v = 0; v < 256; v++) begin
            for (int i = 0; i < BL; i++) b[i] = v;
            send_block(b, 0, (v == 3) ? "R8" : "");
        end
        // alternating pairs, pauses on some blocks
        for (int a = 0; a < 16; a++)
            for (int c = 0; c < 16; c++) begin
                for (int i = 0; i < BL; i++) b[i] = (i % 2 == 0) ? a : c;
                send_block(b, ((a + c) % 3 == 0) ? 1 : 0, "");
            end
        // pseudo-random mixed blocks
        for (int n = 0; n < 150; n++) begin
            for (int i = 0; i < BL; i++) b[i] = next_val();
            send_block(b, n % 2, "");
        end
        // R9: second-extension sum 65545 must saturate, not wrap to a small value
        for (int i = 0; i < BL; i++) b[i] = 0;
        b[0] = 161; b[1] = 200;
        send_block(b, 0, "R9");
        // R11: non-zero block immediately followed by all-zero block
        for (int i = 0; i < BL; i++) b[i] = 5;
        send_block(b, 0, "");
        for (int i = 0; i < BL; i++) b[i] = 0;
        send_block(b, 0, "R11");
        drain();

        // R10: partial block discarded by reset
        for (int i = 0; i < 3; i++) step(1'b1, 200, 1'b0);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        p0_v = 0; p1_v = 0;
        @(negedge clk);
        chk(dec_valid == 1'b0, "R10", "valid during reset", int'(dec_valid), 0);
        rst = 1'b0;
        for (int i = 0; i < BL; i++) b[i] = 0;
        send_block(b, 0, "R10");
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule